// File: doc/BRIEF.md
# Posted Write Merging Buffer

This block sits between an upstream request port and a downstream bus port. Upstream writes carry a 32-bit word address, per-lane byte enables, data and a space flag that marks them as memory or I/O. Each write is posted. The upstream side sees it complete as soon as the buffer takes it, and the buffer sends it downstream later, one entry at a time and in arrival order.

A memory write that hits the same word as the youngest queued entry does not take a new slot. It folds into that entry. Its enable bits are ORed into the entry and its lanes overwrite the stored data. Two single-byte stores to one word can therefore leave as one access with a non-contiguous enable pattern. I/O writes never fold.

A read acts as a fence. The buffer takes the read, stops taking new requests, and waits until every queued write has left. It then sends the read on the same downstream port with a read flag, and passes the downstream response back to the upstream side.

Top module: `posted_wr_merger`

## Requirements
- R1: A write is accepted (up_valid and up_ready both high) while the downstream port is stalled, as long as a slot is free. Accepted writes leave the downstream port in the order they were accepted.
- R2: A memory write (up_is_io=0) to the same word address as the youngest queued memory entry merges into that entry and takes no new slot. A merge is also accepted when the queue is full.
- R3: A merge ORs the byte enables into the entry. Byte-enable bit i selects data bits 8i+7..8i. Lanes enabled by the newer write take the newer data. For example, lanes 0 and 2 give the pattern 0101.
- R4: An I/O write (up_is_io=1) never merges, and it is never a merge target. Each one leaves as its own downstream access with dn_is_io=1.
- R5: Only the youngest entry is a merge target. A write to a different word takes a new slot. A later write back to an earlier word also takes a new slot when another word lies between them.
- R6: up_ready is low for a write that needs a new slot while DEPTH entries are queued.
- R7: A write with up_be=0000 is accepted and discarded. It neither creates nor changes an entry.
- R8: A read (up_is_read=1) is accepted and then blocks all further upstream requests. It is presented downstream, with dn_is_read=1 and its own address, enables and space flag, only after every earlier write has left.
- R9: After the read handshake downstream, dn_rsp_valid/dn_rsp_data appear on up_rsp_valid/up_rsp_data in the same cycle. The buffer then accepts requests again.
- R10: A synchronous active-high reset empties the queue and cancels a pending read. After reset, dn_valid=0 and up_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_is_read | input | 1 | Request is a read |
| up_is_io | input | 1 | Request targets I/O space |
| up_addr | input | ADDR_W | Word address |
| up_be | input | 4 | Byte enables, bit i for lane i |
| up_wdata | input | 32 | Write data |
| up_rsp_valid | output | 1 | Read response to upstream |
| up_rsp_data | output | 32 | Read response data |
| dn_valid | output | 1 | Downstream access valid |
| dn_ready | input | 1 | Downstream accepts the access |
| dn_is_read | output | 1 | Downstream access is a read |
| dn_is_io | output | 1 | Downstream access targets I/O space |
| dn_addr | output | ADDR_W | Downstream word address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data (zero for reads) |
| dn_rsp_valid | input | 1 | Read response from downstream |
| dn_rsp_data | input | 32 | Read response data from downstream |

## Verification
The assertions assume that requests and responses follow the handshake: an upstream request counts only in a cycle where up_ready is high, and dn_rsp_valid is meaningful only after the read has been issued downstream. The bench raises dn_rsp_valid only while its reference model holds a read waiting for its response. It draws addresses from a handful of words so that merges, I/O collisions and full-queue stalls occur often. It also holds dn_ready low in some stretches so that entries sit in the queue long enough to be merge targets.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef struct packed {
        logic             io;
        logic [LANES-1:0] be;
        logic [DATA_W-1:0] data;
    } wr_payload_t;

    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_DRAIN = 2'd1,
        BR_WAIT  = 2'd2
    } bar_state_e;

    // Overlay the enabled lanes of new_d onto old_d.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_d,
        input logic [DATA_W-1:0] new_d,
        input logic [LANES-1:0]  new_be
    );
        logic [DATA_W-1:0] r;
        r = old_d;
        for (int i = 0; i < LANES; i++) begin
            if (new_be[i]) r[i*8 +: 8] = new_d[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wpm_queue.sv
module wpm_queue
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DEPTH  = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  wr_payload_t       push_pl,
    input  logic              merge,
    input  logic [LANES-1:0]  merge_be,
    input  logic [DATA_W-1:0] merge_data,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic              single,
    output logic [CW-1:0]     count,
    output logic [ADDR_W-1:0] head_addr,
    output wr_payload_t       head_pl,
    output logic [ADDR_W-1:0] tail_addr,
    output logic              tail_io
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    wr_payload_t       pl_q   [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     last_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign last_ptr  = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign single    = (count == CW'(1));
    assign head_addr = addr_q[rd_ptr];
    assign head_pl   = pl_q[rd_ptr];
    assign tail_addr = addr_q[last_ptr];
    assign tail_io   = pl_q[last_ptr].io;

    // Slot storage: a push fills the slot at wr_ptr, a merge updates the youngest slot.
    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (push && wr_ptr == PW'(s)) begin
                addr_q[s] <= push_addr;
                pl_q[s]   <= push_pl;
            end else if (merge && last_ptr == PW'(s)) begin
                pl_q[s].be   <= pl_q[s].be | merge_be;
                pl_q[s].data <= lane_merge(pl_q[s].data, merge_data, merge_be);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count < CW'(DEPTH)));

    assert_merge_has_target_R2: assert property (@(posedge clk) disable iff (rst)
        merge |-> !empty);

    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/wpm_merge_ctl.sv
module wpm_merge_ctl
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              up_valid,
    input  logic              up_is_read,
    input  logic              up_is_io,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LANES-1:0]  up_be,
    input  logic              q_empty,
    input  logic              q_full,
    input  logic              q_single,
    input  logic              pop,
    input  logic [ADDR_W-1:0] tail_addr,
    input  logic              tail_io,
    input  logic              bar_idle,
    output logic              up_ready,
    output logic              push,
    output logic              merge,
    output logic              drop,
    output logic              rd_accept
);

    logic tail_leaving;
    logic can_merge;
    logic zero_be;
    logic fire;

    // The youngest entry is off limits when it is also the head being handed over.
    assign tail_leaving = pop && q_single;
    assign can_merge    = !q_empty && !tail_leaving && !up_is_io && !tail_io
                          && (tail_addr == up_addr);
    assign zero_be      = ~|up_be;

    assign up_ready  = bar_idle && (up_is_read || zero_be || can_merge || !q_full);
    assign fire      = up_valid && up_ready;
    assign rd_accept = fire && up_is_read;
    assign drop      = fire && !up_is_read && zero_be;
    assign merge     = fire && !up_is_read && !zero_be && can_merge;
    assign push      = fire && !up_is_read && !zero_be && !can_merge;

endmodule

// File: rtl/wpm_barrier.sv
module wpm_barrier
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    input  logic              in_io,
    input  logic              q_empty,
    input  logic              dn_ready,
    input  logic              dn_rsp_valid,
    output logic              idle,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0]  rd_be,
    output logic              rd_io,
    output logic              rsp_ok
);

    bar_state_e state;

    assign idle   = (state == BR_IDLE);
    assign rd_req = (state == BR_DRAIN) && q_empty;
    assign rsp_ok = (state == BR_WAIT) && dn_rsp_valid;

    always_ff @(posedge clk) begin
        if (rd_accept) begin
            rd_addr <= in_addr;
            rd_be   <= in_be;
            rd_io   <= in_io;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BR_IDLE;
        end else begin
            case (state)
                BR_IDLE:  if (rd_accept)           state <= BR_DRAIN;
                BR_DRAIN: if (rd_req && dn_ready)  state <= BR_WAIT;
                BR_WAIT:  if (dn_rsp_valid)        state <= BR_IDLE;
                default:                           state <= BR_IDLE;
            endcase
        end
    end

    assert_accept_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
        rd_accept |-> (state == BR_IDLE));

endmodule

// File: rtl/posted_wr_merger.sv
module posted_wr_merger
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_is_read,
    input  logic              up_is_io,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [3:0]        up_be,
    input  logic [31:0]       up_wdata,
    output logic              up_rsp_valid,
    output logic [31:0]       up_rsp_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_is_read,
    output logic              dn_is_io,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [3:0]        dn_be,
    output logic [31:0]       dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic [31:0]       dn_rsp_data
);

    localparam int CW = $clog2(DEPTH + 1);

    logic              push, merge, drop, rd_accept, pop;
    logic              q_empty, q_full, q_single, tail_io;
    logic [CW-1:0]     q_count;
    logic [ADDR_W-1:0] head_addr, tail_addr;
    wr_payload_t       head_pl, push_pl;
    logic              bar_idle, rd_req, rd_io, rsp_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [LANES-1:0]  rd_be;

    assign push_pl = '{io: up_is_io, be: up_be, data: up_wdata};
    assign pop     = dn_ready && !q_empty;

    wpm_merge_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .up_valid   (up_valid),
        .up_is_read (up_is_read),
        .up_is_io   (up_is_io),
        .up_addr    (up_addr),
        .up_be      (up_be),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .q_single   (q_single),
        .pop        (pop),
        .tail_addr  (tail_addr),
        .tail_io    (tail_io),
        .bar_idle   (bar_idle),
        .up_ready   (up_ready),
        .push       (push),
        .merge      (merge),
        .drop       (drop),
        .rd_accept  (rd_accept)
    );

    wpm_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_q (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_addr  (up_addr),
        .push_pl    (push_pl),
        .merge      (merge),
        .merge_be   (up_be),
        .merge_data (up_wdata),
        .pop        (pop),
        .empty      (q_empty),
        .full       (q_full),
        .single     (q_single),
        .count      (q_count),
        .head_addr  (head_addr),
        .head_pl    (head_pl),
        .tail_addr  (tail_addr),
        .tail_io    (tail_io)
    );

    wpm_barrier #(.ADDR_W(ADDR_W)) u_bar (
        .clk          (clk),
        .rst          (rst),
        .rd_accept    (rd_accept),
        .in_addr      (up_addr),
        .in_be        (up_be),
        .in_io        (up_is_io),
        .q_empty      (q_empty),
        .dn_ready     (dn_ready),
        .dn_rsp_valid (dn_rsp_valid),
        .idle         (bar_idle),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_be        (rd_be),
        .rd_io        (rd_io),
        .rsp_ok       (rsp_ok)
    );

    always_comb begin
        dn_valid   = !q_empty || rd_req;
        dn_is_read = 1'b0;
        dn_addr    = head_addr;
        dn_be      = head_pl.be;
        dn_wdata   = head_pl.data;
        dn_is_io   = head_pl.io;
        if (q_empty) begin
            dn_is_read = rd_req;
            dn_addr    = rd_addr;
            dn_be      = rd_be;
            dn_wdata   = '0;
            dn_is_io   = rd_io;
        end
    end

    assign up_rsp_valid = rsp_ok;
    assign up_rsp_data  = dn_rsp_data;

    assert_io_never_merges_R4: assert property (@(posedge clk) disable iff (rst)
        merge |-> !up_is_io);

    assert_zero_be_no_change_R7: assert property (@(posedge clk) disable iff (rst)
        (drop && !pop) |=> (q_count == $past(q_count)));

    assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_is_read) |-> q_empty);

    assert_blocked_during_read_R8: assert property (@(posedge clk) disable iff (rst)
        !bar_idle |-> !up_ready);

    assert_release_after_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        up_rsp_valid |=> bar_idle);

endmodule

// File: tb/sim_posted_wr_merger.sv
module sim_posted_wr_merger;

    localparam int AW    = 30;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_valid = 1'b0, up_is_read = 1'b0, up_is_io = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [3:0]    up_be = '0;
    logic [31:0]   up_wdata = '0;
    logic          up_ready, up_rsp_valid;
    logic [31:0]   up_rsp_data;
    logic          dn_valid, dn_is_read, dn_is_io;
    logic          dn_ready = 1'b0, dn_rsp_valid = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [3:0]    dn_be;
    logic [31:0]   dn_wdata, dn_rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [AW-1:0] m_addr [$];
    logic [3:0]    m_be   [$];
    logic [31:0]   m_data [$];
    logic          m_io   [$];
    int            m_br;          // 0 idle, 1 draining, 2 awaiting response
    logic [AW-1:0] m_raddr;
    logic [3:0]    m_rbe;
    logic          m_rio;

    always #4 clk = ~clk;

    posted_wr_merger #(.ADDR_W(AW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_ready(up_ready), .up_is_read(up_is_read),
        .up_is_io(up_is_io), .up_addr(up_addr), .up_be(up_be), .up_wdata(up_wdata),
        .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_is_read(dn_is_read),
        .dn_is_io(dn_is_io), .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic rd, input logic io, input logic [AW-1:0] a,
                         input logic [3:0] be, input logic [31:0] d, input logic dr,
                         input logic rv, input logic [31:0] rdat);
        up_valid = v; up_is_read = rd; up_is_io = io; up_addr = a;
        up_be = be; up_wdata = d; dn_ready = dr; dn_rsp_valid = rv; dn_rsp_data = rdat;
        #1;
    endtask

    // Set inputs, look without a clock edge.
    task automatic peek();
        drive(1'b0, 1'b0, 1'b0, '0, 4'h0, '0, 1'b0, 1'b0, '0);
    endtask

    // One clock: compare against the model, then advance the model.
    task automatic cyc(input logic v, input logic rd, input logic io, input logic [AW-1:0] a,
                       input logic [3:0] be, input logic [31:0] d, input logic dr,
                       input logic rv, input logic [31:0] rdat);
        int n, old_br;
        logic mg, e_rdy, e_dv, e_rsp;
        drive(v, rd, io, a, be, d, dr, rv, rdat);
        n  = m_addr.size();
        mg = 1'b0;
        if (n > 0) mg = !io && !m_io[n-1] && (m_addr[n-1] == a) && !(n == 1 && dr);
        e_rdy = (m_br == 0) && (rd || be == 4'h0 || mg || n < DEPTH);
        e_dv  = (n > 0) || (m_br == 1);
        e_rsp = (m_br == 2) && rv;
        chk(up_ready == e_rdy, "R6 up_ready", 32'(up_ready), 32'(e_rdy));
        chk(dn_valid == e_dv, "R1 dn_valid", 32'(dn_valid), 32'(e_dv));
        chk(up_rsp_valid == e_rsp, "R9 up_rsp_valid", 32'(up_rsp_valid), 32'(e_rsp));
        if (e_rsp) chk(up_rsp_data == rdat, "R9 up_rsp_data", up_rsp_data, rdat);
        if (e_dv && n > 0) begin
            chk(!dn_is_read, "R1 dn_is_read", 32'(dn_is_read), 32'd0);
            chk(dn_addr == m_addr[0], "R5 dn_addr", 32'(dn_addr), 32'(m_addr[0]));
            chk(dn_be == m_be[0], "R3 dn_be", 32'(dn_be), 32'(m_be[0]));
            chk(dn_wdata == m_data[0], "R3 dn_wdata", dn_wdata, m_data[0]);
            chk(dn_is_io == m_io[0], "R4 dn_is_io", 32'(dn_is_io), 32'(m_io[0]));
        end else if (e_dv) begin
            chk(dn_is_read, "R8 dn_is_read", 32'(dn_is_read), 32'd1);
            chk(dn_addr == m_raddr, "R8 dn_addr", 32'(dn_addr), 32'(m_raddr));
            chk(dn_be == m_rbe, "R8 dn_be", 32'(dn_be), 32'(m_rbe));
            chk(dn_is_io == m_rio, "R8 dn_is_io", 32'(dn_is_io), 32'(m_rio));
        end
        @(posedge clk);
        old_br = m_br;
        if (e_dv && dr) begin
            if (n > 0) begin
                void'(m_addr.pop_front()); void'(m_be.pop_front());
                void'(m_data.pop_front()); void'(m_io.pop_front());
            end else begin
                m_br = 2;
            end
        end
        if (old_br == 2 && rv) m_br = 0;
        if (v && e_rdy) begin
            if (rd) begin
                m_br = 1; m_raddr = a; m_rbe = be; m_rio = io;
            end else if (be != 4'h0) begin
                if (mg) begin
                    int k;
                    k = m_addr.size() - 1;
                    for (int i = 0; i < 4; i++)
                        if (be[i]) m_data[k][i*8 +: 8] = d[i*8 +: 8];
                    m_be[k] = m_be[k] | be;
                end else begin
                    m_addr.push_back(a); m_be.push_back(be);
                    m_data.push_back(d); m_io.push_back(io);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic io, input logic [AW-1:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic dr);
        cyc(1'b1, 1'b0, io, a, be, d, dr, 1'b0, '0);
    endtask

    task automatic idle(input logic dr, input logic rv, input logic [31:0] rdat);
        cyc(1'b0, 1'b0, 1'b0, '0, 4'h0, '0, dr, rv, rdat);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        peek();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_addr.delete(); m_be.delete(); m_data.delete(); m_io.delete();
        m_br = 0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_br = 0; m_raddr = '0; m_rbe = '0; m_rio = 1'b0;
        @(negedge clk);
        do_reset();

        // R10: reset state
        peek();
        chk(!dn_valid, "R10 dn_valid after reset", 32'(dn_valid), 32'd0);
        chk(up_ready, "R10 up_ready after reset", 32'(up_ready), 32'd1);

        // R2/R3: lanes 0 and 2 fold into one entry with pattern 0101
        wr(1'b0, 30'h10, 4'b0001, 32'h0000_00AA, 1'b0);
        wr(1'b0, 30'h10, 4'b0100, 32'h00CC_0000, 1'b0);
        peek();
        chk(dn_be == 4'b0101, "R3 non-contiguous be", 32'(dn_be), 32'h5);
        chk(dn_wdata == 32'h00CC_00AA, "R3 merged data", dn_wdata, 32'h00CC_00AA);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(!dn_valid, "R2 merge took one slot", 32'(dn_valid), 32'd0);

        // R3: overlapping lane takes the newer data
        wr(1'b0, 30'h20, 4'b0011, 32'h0000_1111, 1'b0);
        wr(1'b0, 30'h20, 4'b0010, 32'h0000_2200, 1'b0);
        peek();
        chk(dn_wdata == 32'h0000_2211, "R3 overlap data", dn_wdata, 32'h0000_2211);
        chk(dn_be == 4'b0011, "R3 overlap be", 32'(dn_be), 32'h3);
        idle(1'b1, 1'b0, '0);

        // R4: I/O writes to one word stay separate
        wr(1'b1, 30'h30, 4'b0001, 32'h0000_0001, 1'b0);
        wr(1'b1, 30'h30, 4'b0100, 32'h0002_0000, 1'b0);
        peek();
        chk(dn_be == 4'b0001 && dn_is_io, "R4 first io access", 32'(dn_be), 32'h1);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(dn_valid && dn_be == 4'b0100, "R4 second io access", 32'(dn_be), 32'h4);
        idle(1'b1, 1'b0, '0);

        // R7: zero enables change nothing
        wr(1'b0, 30'h40, 4'b0010, 32'h0000_5500, 1'b0);
        wr(1'b0, 30'h40, 4'b0000, 32'hFFFF_FFFF, 1'b0);
        peek();
        chk(dn_be == 4'b0010 && dn_wdata == 32'h0000_5500, "R7 entry unchanged", dn_wdata, 32'h0000_5500);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(!dn_valid, "R7 no entry created", 32'(dn_valid), 32'd0);

        // R5: only the youngest entry merges
        wr(1'b0, 30'h50, 4'b0001, 32'h11, 1'b0);
        wr(1'b0, 30'h51, 4'b0001, 32'h22, 1'b0);
        wr(1'b0, 30'h50, 4'b0010, 32'h3300, 1'b0);
        peek();
        chk(dn_addr == 30'h50 && dn_be == 4'b0001, "R5 first entry", 32'(dn_addr), 32'h50);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(dn_addr == 30'h51, "R5 second entry", 32'(dn_addr), 32'h51);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(dn_addr == 30'h50 && dn_be == 4'b0010, "R5 third entry", 32'(dn_be), 32'h2);
        idle(1'b1, 1'b0, '0);

        // R6/R2: full queue refuses new slot, takes a merge
        for (int i = 0; i < DEPTH; i++) wr(1'b0, AW'(32'h60 + i), 4'hF, 32'(i), 1'b0);
        drive(1'b1, 1'b0, 1'b0, 30'h70, 4'hF, '0, 1'b0, 1'b0, '0);
        chk(!up_ready, "R6 full blocks new word", 32'(up_ready), 32'd0);
        drive(1'b1, 1'b0, 1'b0, AW'(32'h60 + DEPTH - 1), 4'b0001, '0, 1'b0, 1'b0, '0);
        chk(up_ready, "R2 merge accepted when full", 32'(up_ready), 32'd1);
        for (int i = 0; i < DEPTH; i++) idle(1'b1, 1'b0, '0);

        // R8/R9: read drains earlier writes, then completes
        wr(1'b0, 30'h70, 4'hF, 32'hA5A5_A5A5, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 30'h71, 4'hF, '0, 1'b0, 1'b0, '0);
        drive(1'b1, 1'b0, 1'b0, 30'h72, 4'hF, '0, 1'b0, 1'b0, '0);
        chk(!up_ready, "R8 blocked behind read", 32'(up_ready), 32'd0);
        chk(dn_valid && !dn_is_read && dn_addr == 30'h70, "R8 write drains first", 32'(dn_is_read), 32'd0);
        idle(1'b1, 1'b0, '0);
        peek();
        chk(dn_valid && dn_is_read && dn_addr == 30'h71, "R8 read presented", 32'(dn_addr), 32'h71);
        idle(1'b1, 1'b0, '0);
        drive(1'b0, 1'b0, 1'b0, '0, 4'h0, '0, 1'b0, 1'b1, 32'hDEAD_BEEF);
        chk(up_rsp_valid && up_rsp_data == 32'hDEAD_BEEF, "R9 response passed", up_rsp_data, 32'hDEAD_BEEF);
        idle(1'b0, 1'b1, 32'hDEAD_BEEF);
        drive(1'b1, 1'b0, 1'b0, 30'h72, 4'hF, '0, 1'b0, 1'b0, '0);
        chk(up_ready, "R9 released after response", 32'(up_ready), 32'd1);

        // R10: reset clears queue and pending read
        wr(1'b0, 30'h80, 4'hF, 32'h1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 30'h81, 4'hF, '0, 1'b0, 1'b0, '0);
        do_reset();
        drive(1'b1, 1'b0, 1'b0, 30'h82, 4'hF, '0, 1'b0, 1'b0, '0);
        chk(!dn_valid, "R10 queue emptied", 32'(dn_valid), 32'd0);
        chk(up_ready, "R10 read cancelled", 32'(up_ready), 32'd1);

        // Mixed traffic on a few words, checked every clock
        for (int t = 0; t < 4000; t++) begin
            logic v, rd, io, dr, rv;
            logic [AW-1:0] a;
            v  = ($urandom % 4) != 0;
            rd = ($urandom % 16) == 0;
            io = ($urandom % 5) == 0;
            a  = AW'($urandom % 3);
            dr = (t % 200 < 60) ? (($urandom % 5) == 0) : (($urandom % 3) != 0);
            rv = (m_br == 2) && (($urandom % 2) == 0);
            cyc(v, rd, io, a, 4'($urandom), $urandom, dr, rv, $urandom);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule